// File: doc/BRIEF.md
# Tree Pseudo-LRU Victim Selector

This block keeps an approximate recency record for every set of an eight-way set-associative cache and names the way to evict when a miss needs room. Each set owns a small binary tree of direction bits. The eight ways are the leaves of a tree three levels deep. Each internal node remembers which of its two subtrees saw the most recent access. Exact recency ordering would need a read-modify-write of an ordering list on every hit. This tree needs only a blind write of three bits on the path of the touched way.

Hits and fills use one access strobe that carries the set and the way. A victim request carries a set index, and the answer appears one cycle later. A small response state machine has two states, `ST_IDLE` and `ST_DELIVER`, and four transitions:
- *request accepted* takes it from `ST_IDLE` to `ST_DELIVER`.
- *back-to-back* keeps it in `ST_DELIVER` when another request arrives.
- *release* takes it from `ST_DELIVER` back to `ST_IDLE`.
- *stay idle* keeps it in `ST_IDLE` when no request arrives.

A mode input replaces the tree walk with a pseudo-random pick taken from a free-running shift register.

Top module: `plru_victim_sel`

## Requirements
- R1: While reset is asserted and after it is released, `vic_valid` is low, and every node bit of every set is clear. The first tree-mode victim of every set is therefore way 0.
- R2: `vic_valid` is high in the cycle after a cycle in which `vic_req` was high, and low in the cycle after a cycle in which it was low. `vic_way` carries the answer to that request.
- R3: An access to way w of set s writes the three nodes on the path to w. Node 0 is the root. Nodes 1 and 2 cover ways 0-3 and 4-7. Nodes 3, 4, 5 and 6 cover the way pairs 0-1, 2-3, 4-5 and 6-7. A node bit of 1 means the left (lower-numbered) subtree was accessed last. A node bit of 0 means the right subtree was accessed last.
- R4: In tree mode, the victim is found by starting at the root and taking the right branch when the node bit is 1 and the left branch when it is 0. Each branch taken supplies the next victim bit, most significant first. Here 0 means left and 1 means right.
- R5: Until the next access to the same set, the way most recently accessed in a set is never that set's tree victim.
- R6: An access changes only the accessed set. A cycle without an access changes no set.
- R7: When an access and a victim request name the same set in the same cycle, the victim is taken from the tree as it was before that access.
- R8: In random mode (`rand_mode` = 1), `vic_way` equals bits [2:0] of an 8-bit shift register, sampled in the request cycle. The register resets to 0x01 and shifts left every cycle. Its new bit 0 is the XOR of bits 7, 5, 4 and 3. The register is never zero.
- R9: Accesses made while random mode is selected still update the trees. Tree-mode victims afterwards reflect them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access strobe (hit or fill) |
| acc_set | input | SET_W | Set index of the access |
| acc_way | input | WAY_W | Way touched by the access |
| vic_req | input | 1 | Victim request |
| vic_set | input | SET_W | Set index of the victim request |
| rand_mode | input | 1 | 1 selects pseudo-random victims, 0 the tree walk |
| vic_valid | output | 1 | Victim answer present this cycle |
| vic_way | output | WAY_W | Chosen victim way |

## Verification
The bench first touches every way of every set once and then asks for that set's victim. This separates faults in each node index and each bit polarity of the path update and the walk. Ascending, descending and scattered access orders on one set catch mistakes in which tree level feeds which victim bit. Interleaving traffic on other sets shows whether state leaks between sets. Same-cycle access and request pairs tell pre-update from post-update reads. A random-mode stretch with accesses in flight, followed by tree-mode requests, tells the shift-register pick apart from the tree. It also shows whether the tree kept learning while it was not in use.

// File: rtl/plru_pkg.sv
package plru_pkg;

    // Response state of the victim port.
    typedef enum logic [0:0] {
        ST_IDLE    = 1'b0,
        ST_DELIVER = 1'b1
    } vic_state_e;

    // Replacement policy selected by the mode input.
    typedef enum logic [0:0] {
        POL_TREE   = 1'b0,
        POL_RANDOM = 1'b1
    } vic_policy_e;

endpackage

// File: rtl/plru_node_store.sv
module plru_node_store #(
    parameter int NUM_SETS = 16,
    parameter int WAYS     = 8,
    localparam int SET_W   = $clog2(NUM_SETS),
    localparam int WAY_W   = $clog2(WAYS),
    localparam int NODES   = WAYS - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic [SET_W-1:0] acc_set,
    input  logic [WAY_W-1:0] acc_way,
    input  logic [SET_W-1:0] rd_set,
    output logic [NODES-1:0] rd_nodes
);

    logic [NODES-1:0] node_q [NUM_SETS];
    logic [NODES-1:0] upd_mask;
    logic [NODES-1:0] upd_val;

    // Nodes on the path to a way: at level l the node index is
    // (2^l - 1) + (way prefix of l bits).
    function automatic logic [NODES-1:0] path_mask(input logic [WAY_W-1:0] w);
        logic [NODES-1:0] m;
        m = '0;
        for (int l = 0; l < WAY_W; l++) begin
            m[(1 << l) - 1 + int'(w >> (WAY_W - l))] = 1'b1;
        end
        return m;
    endfunction

    // Bit written at each path node: 1 when the way lies in the left subtree.
    function automatic logic [NODES-1:0] path_val(input logic [WAY_W-1:0] w);
        logic [NODES-1:0] v;
        v = '0;
        for (int l = 0; l < WAY_W; l++) begin
            v[(1 << l) - 1 + int'(w >> (WAY_W - l))] = ~w[WAY_W-1-l];
        end
        return v;
    endfunction

    always_comb begin
        upd_mask = path_mask(acc_way);
        upd_val  = path_val(acc_way);
    end

    generate
        for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    node_q[s] <= '0;
                end else if (acc_valid && (acc_set == SET_W'(s))) begin
                    node_q[s] <= (node_q[s] & ~upd_mask) | (upd_val & upd_mask);
                end
            end

            AST_OTHER_SET_HELD: assert property (@(posedge clk) disable iff (!rst_n)
                !(acc_valid && (acc_set == SET_W'(s))) |=> $stable(node_q[s]))
                else $error("set changed without an access to it"); // R6
        end
    endgenerate

    assign rd_nodes = node_q[rd_set];

    // Checker-side victim walk, written in prefix form.
    function automatic logic [WAY_W-1:0] first_victim(input logic [NODES-1:0] n);
        int prefix;
        prefix = 0;
        for (int l = 0; l < WAY_W; l++) begin
            prefix = prefix * 2 + int'(n[(1 << l) - 1 + prefix]);
        end
        return WAY_W'(prefix);
    endfunction

    AST_MRU_NOT_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> (first_victim(node_q[$past(acc_set)]) != $past(acc_way)))
        else $error("just-accessed way selected as victim"); // R5

endmodule

// File: rtl/plru_tree_walk.sv
module plru_tree_walk #(
    parameter int WAYS    = 8,
    localparam int WAY_W  = $clog2(WAYS),
    localparam int NODES  = WAYS - 1
) (
    input  logic [NODES-1:0] nodes,
    output logic [WAY_W-1:0] victim
);

    // Descend from the root, leaving each node on the side not used last.
    always_comb begin
        int   idx;
        logic b;
        idx    = 0;
        victim = '0;
        for (int l = 0; l < WAY_W; l++) begin
            b                   = nodes[idx];
            victim[WAY_W-1-l]   = b;
            idx                 = 2 * idx + 1 + int'(b);
        end
    end

endmodule

// File: rtl/plru_lfsr.sv
module plru_lfsr #(
    parameter int              WIDTH = 8,
    parameter int              OUT_W = 3,
    parameter logic [WIDTH-1:0] SEED = WIDTH'(1),
    parameter logic [WIDTH-1:0] TAPS = WIDTH'(8'hB8)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [OUT_W-1:0] rnd
);

    logic [WIDTH-1:0] q;
    logic             fb;

    assign fb = ^(q & TAPS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= SEED;
        end else begin
            q <= {q[WIDTH-2:0], fb};
        end
    end

    assign rnd = q[OUT_W-1:0];

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        q != '0)
        else $error("shift register reached zero"); // R8

    AST_LFSR_SHIFTS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (q[WIDTH-1:1] == $past(q[WIDTH-2:0])))
        else $error("shift register did not shift"); // R8

endmodule

// File: rtl/plru_victim_fsm.sv
module plru_victim_fsm
    import plru_pkg::*;
#(
    parameter int WAY_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vic_req,
    input  logic             rand_mode,
    input  logic [WAY_W-1:0] tree_way,
    input  logic [WAY_W-1:0] rnd_way,
    output logic             vic_valid,
    output logic [WAY_W-1:0] vic_way
);

    vic_state_e  state_q;
    vic_state_e  state_d;
    vic_policy_e policy;
    logic [WAY_W-1:0] way_q;

    assign policy = vic_policy_e'(rand_mode);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    state_d = vic_req ? ST_DELIVER : ST_IDLE;    // request accepted / stay idle
            ST_DELIVER: state_d = vic_req ? ST_DELIVER : ST_IDLE;    // back-to-back / release
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register: answer captured in the request cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            way_q <= '0;
        end else if (vic_req) begin
            way_q <= (policy == POL_RANDOM) ? rnd_way : tree_way;
        end
    end

    assign vic_valid = (state_q == ST_DELIVER);
    assign vic_way   = way_q;

    AST_REQ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        vic_req |=> vic_valid)
        else $error("request not answered"); // R2

    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !vic_req |=> !vic_valid)
        else $error("valid without request"); // R2

    AST_RANDOM_PICK: assert property (@(posedge clk) disable iff (!rst_n)
        (vic_req && rand_mode) |=> (vic_way == $past(rnd_way)))
        else $error("random victim mismatch"); // R8

    AST_TREE_PICK: assert property (@(posedge clk) disable iff (!rst_n)
        (vic_req && !rand_mode) |=> (vic_way == $past(tree_way)))
        else $error("tree victim mismatch"); // R4

endmodule

// File: rtl/plru_victim_sel.sv
module plru_victim_sel #(
    parameter int NUM_SETS = 16,
    parameter int WAYS     = 8,
    parameter int RND_W    = 8,
    localparam int SET_W   = $clog2(NUM_SETS),
    localparam int WAY_W   = $clog2(WAYS),
    localparam int NODES   = WAYS - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic [SET_W-1:0] acc_set,
    input  logic [WAY_W-1:0] acc_way,
    input  logic             vic_req,
    input  logic [SET_W-1:0] vic_set,
    input  logic             rand_mode,
    output logic             vic_valid,
    output logic [WAY_W-1:0] vic_way
);

    logic [NODES-1:0] req_nodes;
    logic [WAY_W-1:0] tree_way;
    logic [WAY_W-1:0] rnd_way;

    plru_node_store #(
        .NUM_SETS (NUM_SETS),
        .WAYS     (WAYS)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_valid),
        .acc_set   (acc_set),
        .acc_way   (acc_way),
        .rd_set    (vic_set),
        .rd_nodes  (req_nodes)
    );

    plru_tree_walk #(
        .WAYS (WAYS)
    ) u_walk (
        .nodes  (req_nodes),
        .victim (tree_way)
    );

    plru_lfsr #(
        .WIDTH (RND_W),
        .OUT_W (WAY_W)
    ) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .rnd   (rnd_way)
    );

    plru_victim_fsm #(
        .WAY_W (WAY_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .vic_req   (vic_req),
        .rand_mode (rand_mode),
        .tree_way  (tree_way),
        .rnd_way   (rnd_way),
        .vic_valid (vic_valid),
        .vic_way   (vic_way)
    );

    AST_RESET_IDLE: assert property (@(posedge clk) $rose(rst_n) |-> !vic_valid)
        else $error("valid high out of reset"); // R1

endmodule

// File: tb/plru_victim_sel_tb_top.sv
`timescale 1ns/1ps
module plru_victim_sel_tb_top;

    localparam int NS    = 4;
    localparam int NW    = 8;
    localparam int SET_W = $clog2(NS);
    localparam int WAY_W = $clog2(NW);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             acc_valid = 1'b0;
    logic [SET_W-1:0] acc_set = '0;
    logic [WAY_W-1:0] acc_way = '0;
    logic             vic_req = 1'b0;
    logic [SET_W-1:0] vic_set = '0;
    logic             rand_mode = 1'b0;
    logic             vic_valid;
    logic [WAY_W-1:0] vic_way;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    logic [6:0] mdl [NS];
    logic [7:0] mlfsr;

    always #2 clk = ~clk;

    plru_victim_sel #(.NUM_SETS(NS), .WAYS(NW)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_valid),
        .acc_set   (acc_set),
        .acc_way   (acc_way),
        .vic_req   (vic_req),
        .vic_set   (vic_set),
        .rand_mode (rand_mode),
        .vic_valid (vic_valid),
        .vic_way   (vic_way)
    );

    // Reference shift register per R8.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) mlfsr <= 8'h01;
        else        mlfsr <= {mlfsr[6:0], mlfsr[7] ^ mlfsr[5] ^ mlfsr[4] ^ mlfsr[3]};
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // R3 model: arithmetic node placement.
    task automatic m_acc(input int s, input int w);
        mdl[s][0]           = (w < 4);
        mdl[s][1 + w / 4]   = ((w % 4) < 2);
        mdl[s][3 + w / 2]   = ((w % 2) == 0);
    endtask

    // R4 model: walk by taking the side opposite to the last access.
    function automatic int m_vic(input int s);
        int hi, mid, lo;
        hi  = int'(mdl[s][0]);
        mid = int'(mdl[s][1 + hi]);
        lo  = int'(mdl[s][3 + 2 * hi + mid]);
        return hi * 4 + mid * 2 + lo;
    endfunction

    // One cycle: drive after a falling edge, check after the next falling edge.
    task automatic step(input string tag, input bit av, input int as, input int aw,
                        input bit vr, input int vs, input bit rm);
        int exp_way;
        acc_valid = av;
        acc_set   = SET_W'(as);
        acc_way   = WAY_W'(aw);
        vic_req   = vr;
        vic_set   = SET_W'(vs);
        rand_mode = rm;
        exp_way   = rm ? int'(mlfsr[2:0]) : m_vic(vs);
        if (av) m_acc(as, aw);
        @(posedge clk);
        @(negedge clk);
        acc_valid = 1'b0;
        vic_req   = 1'b0;
        chk("R2 valid", int'(vic_valid), int'(vr));
        if (vr) chk(tag, int'(vic_way), exp_way);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < NS; s++) mdl[s] = '0;
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", int'(vic_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after reset", int'(vic_valid), 0);

        // R1: first victim of every set is way 0.
        for (int s = 0; s < NS; s++) step("R1", 1'b0, 0, 0, 1'b1, s, 1'b0);
        step("R2", 1'b0, 0, 0, 1'b0, 0, 1'b0);

        // R3/R4/R5: every way of every set, then the victim.
        for (int s = 0; s < NS; s++) begin
            for (int w = 0; w < NW; w++) begin
                step("R3", 1'b1, s, w, 1'b0, 0, 1'b0);
                step("R4", 1'b0, 0, 0, 1'b1, s, 1'b0);
                chk("R5", int'(vic_way == WAY_W'(w)), 0);
            end
        end

        // R4: ascending, descending and scattered orders on set 0.
        for (int w = 0; w < NW; w++) step("R4 ascending", 1'b1, 0, w, 1'b1, 0, 1'b0);
        for (int w = NW - 1; w >= 0; w--) step("R4 descending", 1'b1, 0, w, 1'b1, 0, 1'b0);
        for (int i = 0; i < 24; i++) begin
            step("R3 scattered", 1'b1, 0, (i * 5 + 3) % NW, 1'b0, 0, 1'b0);
            step("R4 scattered", 1'b0, 0, 0, 1'b1, 0, 1'b0);
        end

        // R6: traffic on set 1 only, other sets must not move.
        for (int i = 0; i < 16; i++) step("R6 traffic", 1'b1, 1, (i * 3) % NW, 1'b0, 0, 1'b0);
        for (int s = 0; s < NS; s++) step("R6", 1'b0, 0, 0, 1'b1, s, 1'b0);
        // Access on one set while requesting another.
        for (int i = 0; i < 16; i++) step("R6 cross", 1'b1, i % NS, (i * 7) % NW, 1'b1, (i + 1) % NS, 1'b0);

        // R7: access and request on the same set in the same cycle, back to back.
        for (int i = 0; i < 16; i++) step("R7", 1'b1, 2, (i * 3 + 1) % NW, 1'b1, 2, 1'b0);
        step("R7 after", 1'b0, 0, 0, 1'b1, 2, 1'b0);

        // R8: random mode with accesses in flight.
        for (int i = 0; i < 40; i++) step("R8", (i % 2) == 0, 3, (i * 5) % NW, 1'b1, i % NS, 1'b1);
        for (int i = 0; i < 5; i++) step("R8 idle", 1'b0, 0, 0, 1'b0, 0, 1'b1);
        step("R8 late", 1'b0, 0, 0, 1'b1, 0, 1'b1);

        // R9: accesses made in random mode show in later tree victims.
        for (int w = 0; w < NW; w += 2) step("R9 train", 1'b1, 3, w, 1'b0, 0, 1'b1);
        for (int s = 0; s < NS; s++) step("R9", 1'b0, 0, 0, 1'b1, s, 1'b0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule